// File: doc/BRIEF.md
# Frame-Length Histogram Statistics Counters

This block keeps seven frame-size statistics counters for an Ethernet MAC. The transmit and receive paths share the counters. Each completed frame is reported to the block as one event. The event carries a byte length, a good/bad flag and a VLAN-tag flag. The length counts every byte from the destination address through the 4-byte FCS. It does not count the preamble or the start delimiter. The event increments the one counter whose size bin matches, or no counter at all.

Software reaches the counters through a simple register port. Each counter sits on its own 32-bit word. Each counter can be read and written. Three control inputs affect all counters:
- a statistics enable, which gates all increments;
- a synchronous clear-all;
- an auto-zero mode, in which a read returns the counter value and resets that counter.

Top module: `frame_len_stats`

## Requirements
- R1: Word index k = `reg_addr[7:2]` selects a counter, and `reg_addr[1:0]` is ignored. The bins in index order are:
  - 0: exactly 64 bytes
  - 1: 65–127 bytes
  - 2: 128–255 bytes
  - 3: 256–511 bytes
  - 4: 512–1023 bytes
  - 5: 1024–1518 bytes
  - 6: 1519–1522 bytes
- R2: Bin 6 counts a frame only when `ev_good`=1 and `ev_vlan`=1.
- R3: Bins 0–5 count frames regardless of `ev_good` and `ev_vlan`.
- R4: An event with `ev_valid`=1 increments exactly one counter by one, or no counter. No counter increments for frames shorter than 64 bytes, frames longer than 1522 bytes, or 1519–1522-byte frames that are not both good and VLAN-tagged. The increment lands on the clock edge that samples the event.
- R5: Each counter is 18 bits wide. Read data is 32 bits, and bits 31:18 are always zero. `reg_rdata` updates on the clock edge that samples `reg_rd`, and it holds its value otherwise.
- R6: `reg_wr` loads `reg_wdata[17:0]` into the selected counter. A write wins over a same-cycle increment of that counter. Writes to word indices 7 and above change nothing, and reads of those indices return 0.
- R7: With `auto_zero`=1, a read returns the counter value and leaves the counter at 0. With `auto_zero`=0, a read leaves the counter unchanged.
- R8: A counter at 0x3FFFF stays at 0x3FFFF on further increments.
- R9: While `stat_en`=0, no event increments any counter.
- R10: `clr_all`=1 zeroes every counter on the next clock edge. It takes priority over writes, reads and increments.
- R11: Sometimes an auto-zero read and an increment hit the same counter in one cycle. The read then returns the old value and the counter becomes 1.
- R12: After reset every counter reads 0, and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_en | input | 1 | Statistics enable; gates all increments |
| clr_all | input | 1 | Zero every counter on the next edge |
| auto_zero | input | 1 | Reads reset the counter that was read |
| ev_valid | input | 1 | Frame event strobe |
| ev_len | input | 16 | Frame length in bytes, FCS included |
| ev_good | input | 1 | Frame was received or sent without error |
| ev_vlan | input | 1 | Frame carries a VLAN tag |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench sweeps every length from 0 to 1600 bytes and reads back all seven counters after each event. Lengths near the bin edges are swept with all four good/VLAN combinations. This sweep catches:
- a bin boundary that is off by one (63/64/65, 127/128, 1518/1519, 1522/1523), which would land in the wrong counter;
- a VLAN bin that also counts bad or untagged frames.

The bench then targets the corner cases that a weaker design gets wrong:
- A counter written to one below the maximum must stop at 0x3FFFF rather than wrap to zero.
- An auto-zero read in the same cycle as an increment must leave the counter at 1, so the event is not lost.
- A plain read without auto-zero must not clear the counter.
- Unmapped offsets must neither alias onto a real counter nor return stale data.

// File: rtl/fls_pkg.sv
package fls_pkg;

    localparam int unsigned NUM_BINS = 7;
    localparam int unsigned LEN_W    = 16;
    localparam int unsigned DATA_W   = 32;

    // Bin order equals the word index of each counter.
    typedef enum logic [2:0] {
        BIN_64   = 3'd0,
        BIN_127  = 3'd1,
        BIN_255  = 3'd2,
        BIN_511  = 3'd3,
        BIN_1K   = 3'd4,
        BIN_MAX  = 3'd5,
        BIN_VLAN = 3'd6
    } bin_e;

    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] len;
        logic             good;
        logic             vlan;
    } frame_ev_t;

    localparam logic [LEN_W-1:0] LEN_MIN      = LEN_W'(64);
    localparam logic [LEN_W-1:0] LEN_STD_MAX  = LEN_W'(1518);
    localparam logic [LEN_W-1:0] LEN_VLAN_MAX = LEN_W'(1522);

    // One-hot bin hit for a frame event; all zero when no bin matches.
    function automatic logic [NUM_BINS-1:0] bin_hit(frame_ev_t ev);
        logic [NUM_BINS-1:0] h;
        h = '0;
        if (ev.valid) begin
            if (ev.len == LEN_MIN)                                  h[BIN_64]   = 1'b1;
            else if (ev.len > LEN_MIN && ev.len < LEN_W'(128))      h[BIN_127]  = 1'b1;
            else if (ev.len >= LEN_W'(128) && ev.len < LEN_W'(256)) h[BIN_255]  = 1'b1;
            else if (ev.len >= LEN_W'(256) && ev.len < LEN_W'(512)) h[BIN_511]  = 1'b1;
            else if (ev.len >= LEN_W'(512) && ev.len < LEN_W'(1024)) h[BIN_1K]  = 1'b1;
            else if (ev.len >= LEN_W'(1024) && ev.len <= LEN_STD_MAX) h[BIN_MAX] = 1'b1;
            else if (ev.len > LEN_STD_MAX && ev.len <= LEN_VLAN_MAX && ev.good && ev.vlan)
                h[BIN_VLAN] = 1'b1;
        end
        return h;
    endfunction

endpackage

// File: rtl/fls_classifier.sv
module fls_classifier
    import fls_pkg::*;
(
    input  frame_ev_t            ev,
    input  logic                 enable,
    output logic [NUM_BINS-1:0]  hit
);
    always_comb begin
        hit = enable ? bin_hit(ev) : '0;
    end
endmodule

// File: rtl/fls_counter.sv
module fls_counter #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             rd_clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Priority: reset/clear, write, clearing read (keeps a same-cycle event), increment.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (rd_clr) begin
            cnt <= inc ? CNT_W'(1) : '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/frame_len_stats.sv
module frame_len_stats
    import fls_pkg::*;
#(
    parameter int unsigned CNT_W  = 18,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_en,
    input  logic              clr_all,
    input  logic              auto_zero,
    input  logic              ev_valid,
    input  logic [LEN_W-1:0]  ev_len,
    input  logic              ev_good,
    input  logic              ev_vlan,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    frame_ev_t                  ev;
    logic [NUM_BINS-1:0]        hit;
    logic [IDX_W-1:0]           word_idx;
    logic [NUM_BINS-1:0]        sel;
    logic [CNT_W-1:0]           cnt [NUM_BINS];
    logic [NUM_BINS*CNT_W-1:0]  cnt_flat;
    logic [CNT_W-1:0]           rd_val;

    assign ev       = '{valid: ev_valid, len: ev_len, good: ev_good, vlan: ev_vlan};
    assign word_idx = reg_addr[ADDR_W-1:2];

    fls_classifier u_cls (
        .ev     (ev),
        .enable (stat_en),
        .hit    (hit)
    );

    for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
        assign sel[k] = (word_idx == IDX_W'(k));
        assign cnt_flat[k*CNT_W +: CNT_W] = cnt[k];

        fls_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr_all),
            .wr_en  (reg_wr && sel[k]),
            .wr_val (reg_wdata[CNT_W-1:0]),
            .rd_clr (reg_rd && auto_zero && sel[k]),
            .inc    (hit[k]),
            .cnt    (cnt[k])
        );
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_BINS; k++) begin
            if (sel[k]) rd_val = cnt[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= {{(DATA_W-CNT_W){1'b0}}, rd_val};
        end
    end
endmodule

// File: rtl/fls_chk.sv
module fls_chk #(
    parameter int unsigned NUM_BINS = 7,
    parameter int unsigned CNT_W    = 18,
    parameter int unsigned DATA_W   = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      stat_en,
    input logic                      clr_all,
    input logic                      reg_rd,
    input logic                      reg_wr,
    input logic [DATA_W-1:0]         reg_rdata,
    input logic [NUM_BINS*CNT_W-1:0] cnt_flat
);
    // R5
    rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:CNT_W] == '0);

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> cnt_flat == '0);

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_en && !reg_wr && !reg_rd && !clr_all) |=> $stable(cnt_flat));

    for (genvar k = 0; k < NUM_BINS; k++) begin : g_sat
        // R8
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt_flat[k*CNT_W +: CNT_W] == {CNT_W{1'b1}} && !reg_wr && !reg_rd && !clr_all)
            |=> cnt_flat[k*CNT_W +: CNT_W] == {CNT_W{1'b1}});
    end
endmodule

bind frame_len_stats fls_chk #(
    .NUM_BINS (fls_pkg::NUM_BINS),
    .CNT_W    (CNT_W),
    .DATA_W   (fls_pkg::DATA_W)
) u_fls_chk (
    .clk       (clk),
    .rst       (rst),
    .stat_en   (stat_en),
    .clr_all   (clr_all),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .cnt_flat  (cnt_flat)
);

// File: tb/tb_frame_len_stats.sv
module tb_frame_len_stats;
    logic        clk = 1'b0;
    logic        rst;
    logic        stat_en, clr_all, auto_zero;
    logic        ev_valid, ev_good, ev_vlan;
    logic [15:0] ev_len;
    logic [7:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata, reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    frame_len_stats dut (
        .clk(clk), .rst(rst), .stat_en(stat_en), .clr_all(clr_all),
        .auto_zero(auto_zero), .ev_valid(ev_valid), .ev_len(ev_len),
        .ev_good(ev_good), .ev_vlan(ev_vlan), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic int exp_bin(int len, bit good, bit vlan);
        if (len == 64) return 0;
        if (len >= 65 && len <= 127) return 1;
        if (len >= 128 && len <= 255) return 2;
        if (len >= 256 && len <= 511) return 3;
        if (len >= 512 && len <= 1023) return 4;
        if (len >= 1024 && len <= 1518) return 5;
        if (len >= 1519 && len <= 1522 && good && vlan) return 6;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(int idx, int low, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 8'(idx * 4 + low);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'(idx * 4);
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(int len, bit good, bit vlan);
        @(negedge clk);
        ev_len = 16'(len);
        ev_good = good;
        ev_vlan = vlan;
        ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    // Reads every bin with auto-zero and compares against an expected single hit.
    task automatic sweep_check(string req, int bin);
        logic [31:0] v;
        for (int k = 0; k < 7; k++) begin
            rd(k, 0, v);
            check(req, v, (k == bin) ? 32'd1 : 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; stat_en = 1'b1; clr_all = 1'b0; auto_zero = 1'b1;
        ev_valid = 1'b0; ev_len = '0; ev_good = 1'b0; ev_vlan = 1'b0;
        reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        check("R12", reg_rdata, 32'd0);
        for (int k = 0; k < 7; k++) begin
            rd(k, 0, v);
            check("R12", v, 32'd0);
        end

        // R1 R3 R4 full length sweep, good/vlan taken from length bits
        for (int len = 0; len <= 1600; len++) begin
            bit g = len[0];
            bit t = len[1];
            send(len, g, t);
            sweep_check("R1_R3_R4", exp_bin(len, g, t));
        end

        // R2 R3 all flag combinations around the upper edges
        for (int len = 1510; len <= 1530; len++) begin
            for (int c = 0; c < 4; c++) begin
                send(len, c[0], c[1]);
                sweep_check("R2_R3", exp_bin(len, c[0], c[1]));
            end
        end

        // R1 low address bits ignored
        send(200, 1'b0, 1'b0);
        rd(2, 3, v);
        check("R1", v, 32'd1);

        // R7 read without auto-zero keeps the value
        auto_zero = 1'b0;
        send(64, 1'b1, 1'b0);
        send(64, 1'b0, 1'b0);
        rd(0, 0, v); check("R7", v, 32'd2);
        rd(0, 0, v); check("R7", v, 32'd2);
        auto_zero = 1'b1;
        rd(0, 0, v); check("R7", v, 32'd2);
        rd(0, 0, v); check("R7", v, 32'd0);

        // R5 R6 write then readback with upper bits discarded
        wr(3, 32'hFFFF_FFFF);
        rd(3, 0, v); check("R5_R6", v, 32'h0003_FFFF);
        wr(1, 32'h0001_2345);
        rd(1, 0, v); check("R6", v, 32'h0001_2345);

        // R6 unmapped offsets
        wr(7, 32'h0000_0055);
        rd(7, 0, v); check("R6", v, 32'd0);
        for (int k = 0; k < 7; k++) begin
            rd(k, 0, v);
            check("R6", v, 32'd0);
        end

        // R6 write wins over a same-cycle increment
        @(negedge clk);
        reg_addr = 8'd20; reg_wdata = 32'd7; reg_wr = 1'b1;
        ev_len = 16'd1200; ev_good = 1'b1; ev_vlan = 1'b0; ev_valid = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_valid = 1'b0;
        rd(5, 0, v); check("R6", v, 32'd7);

        // R8 saturation
        wr(4, 32'h0003_FFFE);
        send(600, 1'b1, 1'b0);
        send(600, 1'b0, 1'b0);
        send(600, 1'b1, 1'b0);
        rd(4, 0, v); check("R8", v, 32'h0003_FFFF);

        // R9 statistics disabled
        stat_en = 1'b0;
        send(64, 1'b1, 1'b0);
        send(1520, 1'b1, 1'b1);
        stat_en = 1'b1;
        rd(0, 0, v); check("R9", v, 32'd0);
        rd(6, 0, v); check("R9", v, 32'd0);

        // R11 auto-zero read colliding with an increment
        wr(2, 32'd9);
        @(negedge clk);
        reg_addr = 8'd8; reg_rd = 1'b1;
        ev_len = 16'd130; ev_good = 1'b0; ev_vlan = 1'b0; ev_valid = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; ev_valid = 1'b0;
        check("R11", reg_rdata, 32'd9);
        rd(2, 0, v); check("R11", v, 32'd1);

        // R10 clear-all with priority over write
        wr(0, 32'd11); wr(6, 32'd22);
        @(negedge clk);
        clr_all = 1'b1; reg_addr = 8'd4; reg_wdata = 32'd5; reg_wr = 1'b1;
        @(negedge clk);
        clr_all = 1'b0; reg_wr = 1'b0;
        for (int k = 0; k < 7; k++) begin
            rd(k, 0, v);
            check("R10", v, 32'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule